// File: doc/BRIEF.md
# Cartridge CPU-Side Bank Mapper

This block sits on the CPU side of a game-console cartridge and turns each CPU bus cycle into banked memory accesses. It maps a switchable 16 KiB program ROM window, a second program window that can only show the lower 8 KiB half of a 16 KiB bank, a top 8 KiB window fixed to the end of the ROM, and a switchable 8 KiB work RAM window. It also decodes a 256-byte expansion RAM and a small register file, and drives an active-low interrupt line straight from a software-controlled latch bit.

Registers and expansion RAM each appear in two mirrored windows. Address bit 14 tells the windows apart. The window with bit 14 set can be both read and written. The window with bit 14 clear accepts writes only and never drives the CPU data bus, so it cannot cause bus conflicts. Register writes take effect on the falling edge of the M2 phase. The ROM and RAM arrays sit outside the block, which only supplies addresses, selects and write enables for them.

Top module: `cart_prg_mapper`

## Requirements
- R1: A register is hit when address bits 15,13,12,11 are 0,0,1,1; bit 14 is ignored, so the register space covers $1800-$1FFF and $5800-$5FFF. On an accepted write the strobe output `reg_wstb` pulses with exactly the bit equal to address bits 3..0 set.
- R2: A register read in the $5800-$5FFF window with M2 high drives `cpu_doe`=1. For register numbers 1, 2 and 3, `cpu_dout` gives the last byte written to that register, and it gives 0 for any other number. A read in the $1800-$1FFF window leaves `cpu_doe` at 0.
- R3: For addresses $8000-$BFFF, `rom_addr` = bank*16384 + (addr & $3FFF), where bank is bits 4..0 of register 1.
- R4: For addresses $C000-$DFFF, `rom_addr` = bank*16384 + (addr & $1FFF), where bank is bits 4..0 of register 2. Bit 13 of `rom_addr` is always 0 in this window.
- R5: For addresses $E000-$FFFF, `rom_addr` addresses the last 8 KiB of the ROM whatever the register contents are.
- R6: For addresses $6000-$7FFF, `ram_sel`=1 and `ram_addr` = bank*8192 + (addr & $1FFF), where bank is bits 2..0 of register 3. `ram_we` is 1 only when R/W is low and M2 is high.
- R7: `irq_n` is the inverse of bit 5 of register 2. Software can set it and clear it through either register window.
- R8: For addresses where bits 15,13,12,11 are 0,0,1,0, `xram_addr` = addr & $FF. `xram_sel` is 1 for reads only when bit 14 is set, and for writes in both windows. `xram_we` is 1 only on writes with M2 high.
- R9: After reset all registers are 0: bank 0 is mapped in every switchable window and `irq_n` is 1.
- R10: Registers change only on an M2 falling edge with R/W low. A read cycle whose M2 falls leaves them unchanged, and so does a write cycle held with M2 high.
- R11: `rom_sel` is 1 only for reads at $8000-$FFFF. At any moment at most one of `rom_sel`, `ram_sel`, `xram_sel` and the register data drive is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_din | input | 8 | CPU write data |
| cpu_rw | input | 1 | 1 = read, 0 = write |
| cpu_m2 | input | 1 | CPU M2 phase |
| cpu_dout | output | 8 | Register readback data |
| cpu_doe | output | 1 | Drive enable for `cpu_dout` |
| rom_sel | output | 1 | Program ROM select |
| rom_addr | output | 14+PRG_BW | Banked ROM byte address |
| ram_sel | output | 1 | Work RAM select |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 13+WRAM_BW | Banked work RAM byte address |
| xram_sel | output | 1 | Expansion RAM select |
| xram_we | output | 1 | Expansion RAM write enable |
| xram_addr | output | 8 | Expansion RAM byte address |
| reg_wstb | output | 16 | One-hot register write strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench builds the block with its defaults, PRG_BW=5 and WRAM_BW=3. That gives 32 ROM banks and 8 RAM banks, so every ROM bank value can be swept through both switchable ROM windows and every RAM bank can be tried. The 16-bit address space is small enough to sweep every 256-byte page for select exclusivity, both on reads and on writes. All sixteen register numbers are written in both mirrored windows, with the ignored address bits varied between writes.

// File: rtl/cpm_pkg.sv
package cpm_pkg;

  // Register numbers used by this mapper (low address nibble).
  localparam logic [3:0] RNUM_PRG16 = 4'd1;
  localparam logic [3:0] RNUM_PRG8  = 4'd2;
  localparam logic [3:0] RNUM_WRAM  = 4'd3;
  localparam int         IRQ_BIT    = 5;
  localparam int         NUM_RNUM   = 16;

  typedef enum logic [2:0] {
    RGN_NONE,
    RGN_ROM16,
    RGN_ROM8,
    RGN_ROMTOP,
    RGN_WRAM,
    RGN_XRAM,
    RGN_REGS
  } region_e;

  // Region of an address; bit 14 is ignored for the mirrored windows.
  function automatic region_e classify(input logic [15:0] a);
    region_e r;
    r = RGN_NONE;
    if (a[15]) begin
      unique case (a[14:13])
        2'b00, 2'b01: r = RGN_ROM16;
        2'b10:        r = RGN_ROM8;
        default:      r = RGN_ROMTOP;
      endcase
    end else if (a[14:13] == 2'b11) begin
      r = RGN_WRAM;
    end else if (!a[13] && a[12]) begin
      r = a[11] ? RGN_REGS : RGN_XRAM;
    end
    return r;
  endfunction

endpackage

// File: rtl/cpm_decode.sv
module cpm_decode
  import cpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rw,
  input  logic        m2,
  input  logic        m2_fall,
  output logic        reg_wr_en,
  output logic        reg_rd_en,
  output logic        rom_sel,
  output logic        ram_sel,
  output logic        ram_we,
  output logic        xram_sel,
  output logic        xram_we
);

  region_e rgn;
  logic    upper_win;
  logic    is_rom;

  assign rgn       = classify(addr);
  assign upper_win = addr[14];
  assign is_rom    = (rgn == RGN_ROM16) || (rgn == RGN_ROM8) || (rgn == RGN_ROMTOP);

  always_comb begin
    rom_sel   = is_rom && rw;
    ram_sel   = (rgn == RGN_WRAM);
    ram_we    = ram_sel && !rw && m2;
    xram_sel  = (rgn == RGN_XRAM) && (!rw || upper_win);
    xram_we   = (rgn == RGN_XRAM) && !rw && m2;
    reg_wr_en = (rgn == RGN_REGS) && !rw && m2_fall;
    reg_rd_en = (rgn == RGN_REGS) && rw && upper_win && m2;
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_sel, ram_sel, xram_sel, reg_rd_en})); // R11

  AST_XRAM_WE_IS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    xram_we |-> (xram_sel && !rw)); // R8

endmodule

// File: rtl/cpm_regs.sv
module cpm_regs
  import cpm_pkg::*;
#(
  parameter int PRG_BW  = 5,
  parameter int WRAM_BW = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [3:0]           rnum,
  input  logic [7:0]           din,
  output logic [7:0]           rd_data,
  output logic [NUM_RNUM-1:0]  wstb,
  output logic [PRG_BW-1:0]    prg16_bank,
  output logic [PRG_BW-1:0]    prg8_bank,
  output logic [WRAM_BW-1:0]   wram_bank,
  output logic                 irq_latch
);

  localparam int FIRST_R = 1;
  localparam int LAST_R  = 3;

  logic [7:0] reg_q [FIRST_R:LAST_R];

  assign wstb = wr_en ? (NUM_RNUM'(1) << rnum) : '0;

  for (genvar gi = FIRST_R; gi <= LAST_R; gi++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        reg_q[gi] <= '0;
      else if (wstb[gi])
        reg_q[gi] <= din;
    end
  end

  always_comb begin
    unique case (rnum)
      RNUM_PRG16: rd_data = reg_q[1];
      RNUM_PRG8:  rd_data = reg_q[2];
      RNUM_WRAM:  rd_data = reg_q[3];
      default:    rd_data = '0;
    endcase
  end

  assign prg16_bank = reg_q[1][PRG_BW-1:0];
  assign prg8_bank  = reg_q[2][PRG_BW-1:0];
  assign wram_bank  = reg_q[3][WRAM_BW-1:0];
  assign irq_latch  = reg_q[2][IRQ_BIT];

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wstb)); // R1

  AST_IRQ_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wstb[2] |=> (irq_latch == $past(din[IRQ_BIT]))); // R7

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wstb[1] |=> $stable(prg16_bank)); // R10

  AST_RAMBANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wram_bank)); // R10

endmodule

// File: rtl/cpm_addr.sv
module cpm_addr #(
  parameter int PRG_BW  = 5,
  parameter int WRAM_BW = 3,
  localparam int ROM_AW = 14 + PRG_BW,
  localparam int RAM_AW = 13 + WRAM_BW
) (
  input  logic [14:0]         addr,
  input  logic [PRG_BW-1:0]   prg16_bank,
  input  logic [PRG_BW-1:0]   prg8_bank,
  input  logic [WRAM_BW-1:0]  wram_bank,
  output logic [ROM_AW-1:0]   rom_addr,
  output logic [RAM_AW-1:0]   ram_addr
);

  // ROM address for a CPU address in the upper half of the map.
  function automatic logic [ROM_AW-1:0] rom_map(input logic [14:0] a,
                                                input logic [PRG_BW-1:0] b16,
                                                input logic [PRG_BW-1:0] b8);
    logic [ROM_AW-1:0] r;
    unique case (a[14:13])
      2'b00, 2'b01: r = {b16, a[13:0]};
      2'b10:        r = {b8, 1'b0, a[12:0]};
      default:      r = {{(PRG_BW + 1){1'b1}}, a[12:0]};
    endcase
    return r;
  endfunction

  function automatic logic [RAM_AW-1:0] ram_map(input logic [12:0] a,
                                                input logic [WRAM_BW-1:0] b);
    return {b, a};
  endfunction

  assign rom_addr = rom_map(addr, prg16_bank, prg8_bank);
  assign ram_addr = ram_map(addr[12:0], wram_bank);

endmodule

// File: rtl/cart_prg_mapper.sv
module cart_prg_mapper #(
  parameter int PRG_BW  = 5,
  parameter int WRAM_BW = 3,
  localparam int ROM_AW = 14 + PRG_BW,
  localparam int RAM_AW = 13 + WRAM_BW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cpu_addr,
  input  logic [7:0]        cpu_din,
  input  logic              cpu_rw,
  input  logic              cpu_m2,
  output logic [7:0]        cpu_dout,
  output logic              cpu_doe,
  output logic              rom_sel,
  output logic [ROM_AW-1:0] rom_addr,
  output logic              ram_sel,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic              xram_sel,
  output logic              xram_we,
  output logic [7:0]        xram_addr,
  output logic [15:0]       reg_wstb,
  output logic              irq_n
);

  logic               m2_q;
  logic               m2_fall;
  logic               reg_wr_en;
  logic               reg_rd_en;
  logic [7:0]         rd_data;
  logic [PRG_BW-1:0]  prg16_bank;
  logic [PRG_BW-1:0]  prg8_bank;
  logic [WRAM_BW-1:0] wram_bank;
  logic               irq_latch;

  always_ff @(posedge clk) begin
    if (!rst_n) m2_q <= 1'b0;
    else        m2_q <= cpu_m2;
  end

  assign m2_fall = m2_q && !cpu_m2;

  cpm_decode u_decode (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (cpu_addr),
    .rw        (cpu_rw),
    .m2        (cpu_m2),
    .m2_fall   (m2_fall),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .rom_sel   (rom_sel),
    .ram_sel   (ram_sel),
    .ram_we    (ram_we),
    .xram_sel  (xram_sel),
    .xram_we   (xram_we)
  );

  cpm_regs #(.PRG_BW(PRG_BW), .WRAM_BW(WRAM_BW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr_en),
    .rnum       (cpu_addr[3:0]),
    .din        (cpu_din),
    .rd_data    (rd_data),
    .wstb       (reg_wstb),
    .prg16_bank (prg16_bank),
    .prg8_bank  (prg8_bank),
    .wram_bank  (wram_bank),
    .irq_latch  (irq_latch)
  );

  cpm_addr #(.PRG_BW(PRG_BW), .WRAM_BW(WRAM_BW)) u_addr (
    .addr       (cpu_addr[14:0]),
    .prg16_bank (prg16_bank),
    .prg8_bank  (prg8_bank),
    .wram_bank  (wram_bank),
    .rom_addr   (rom_addr),
    .ram_addr   (ram_addr)
  );

  assign cpu_doe   = reg_rd_en;
  assign cpu_dout  = reg_rd_en ? rd_data : 8'h00;
  assign xram_addr = cpu_addr[7:0];
  assign irq_n     = !irq_latch;

  AST_LOWER_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_doe |-> (cpu_addr[14] && cpu_rw)); // R2

  AST_MID_LOW_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && cpu_addr[14:13] == 2'b10) |-> !rom_addr[13]); // R4

  AST_TOP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_sel && cpu_addr[14:13] == 2'b11) |-> (&rom_addr[ROM_AW-1:13])); // R5

  AST_WRITE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (|reg_wstb) |-> (m2_q && !cpu_rw)); // R10

endmodule

// File: tb/cart_prg_mapper_tb_top.sv
`timescale 1ns/1ps
module cart_prg_mapper_tb_top;

  localparam int ROM_AW = 19;
  localparam int RAM_AW = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       cpu_addr = '0;
  logic [7:0]        cpu_din = '0;
  logic              cpu_rw = 1'b1;
  logic              cpu_m2 = 1'b0;
  logic [7:0]        cpu_dout;
  logic              cpu_doe;
  logic              rom_sel;
  logic [ROM_AW-1:0] rom_addr;
  logic              ram_sel;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_addr;
  logic              xram_sel;
  logic              xram_we;
  logic [7:0]        xram_addr;
  logic [15:0]       reg_wstb;
  logic              irq_n;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cart_prg_mapper dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_din(cpu_din),
    .cpu_rw(cpu_rw), .cpu_m2(cpu_m2), .cpu_dout(cpu_dout), .cpu_doe(cpu_doe),
    .rom_sel(rom_sel), .rom_addr(rom_addr), .ram_sel(ram_sel), .ram_we(ram_we),
    .ram_addr(ram_addr), .xram_sel(xram_sel), .xram_we(xram_we),
    .xram_addr(xram_addr), .reg_wstb(reg_wstb), .irq_n(irq_n)
  );

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_idle();
    @(negedge clk);
    cpu_rw = 1'b1;
    cpu_m2 = 1'b0;
  endtask

  // Full write cycle; stb returns the strobe seen while M2 falls.
  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d,
                           output logic [15:0] stb);
    @(negedge clk);
    cpu_addr = a; cpu_din = d; cpu_rw = 1'b0; cpu_m2 = 1'b1;
    @(negedge clk);
    cpu_m2 = 1'b0;
    #1 stb = reg_wstb;
    @(negedge clk);
    cpu_rw = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [15:0] s;
    cpu_write(a, d, s);
  endtask

  // Drive address and phase, then let combinational outputs settle.
  task automatic probe(input logic [15:0] a, input logic rw, input logic m2);
    @(negedge clk);
    cpu_addr = a; cpu_rw = rw; cpu_m2 = m2;
    #1;
  endtask

  function automatic longint exp_rom(input int a, input int b16, input int b8);
    if (a < 'hC000) return longint'(b16) * 16384 + (a % 16384);
    if (a < 'hE000) return longint'(b8) * 16384 + (a % 8192);
    return (longint'(1) << ROM_AW) - 8192 + (a % 8192);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
      summary();
    end
  end

  initial begin
    logic [15:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: reset state
    probe(16'h8123, 1'b1, 1'b1);
    check("R9 irq_n", irq_n, 1);
    check("R9 rom bank 0", rom_addr, exp_rom('h8123, 0, 0));
    probe(16'hC456, 1'b1, 1'b1);
    check("R9 rom8 bank 0", rom_addr, exp_rom('hC456, 0, 0));
    probe(16'h7ABC, 1'b1, 1'b1);
    check("R9 ram bank 0", ram_addr, 'h1ABC);
    probe(16'h5803, 1'b1, 1'b1);
    check("R9 reg3 reads 0", cpu_dout, 0);
    bus_idle();

    // R1: every register number in both windows, ignored bits varied
    for (int n = 0; n < 16; n++) begin
      for (int w = 0; w < 2; w++) begin
        logic [15:0] a;
        a = (w != 0 ? 16'h5800 : 16'h1800) | 16'(n) | 16'((n * 37 + w * 11) % 128) << 4;
        cpu_write(a, 8'h00, s);
        check("R1 strobe", s, longint'(1) << n);
      end
    end

    // R3: all 16K banks at $8000-$BFFF; alternate windows
    for (int b = 0; b < 32; b++) begin
      wr((b % 2 != 0) ? 16'h1801 : 16'h5FF1, 8'(b));
      probe(16'h8000, 1'b1, 1'b1);
      check("R3 8000", rom_addr, exp_rom('h8000, b, 0));
      probe(16'hBFFF, 1'b1, 1'b1);
      check("R3 BFFF", rom_addr, exp_rom('hBFFF, b, 0));
      probe(16'h9A5C, 1'b1, 1'b1);
      check("R3 9A5C", rom_addr, exp_rom('h9A5C, b, 0));
      probe(16'h5801, 1'b1, 1'b1);
      check("R2 readback r1", cpu_dout, b);
      bus_idle();
    end

    // R4: all banks at $C000-$DFFF, lower half only
    for (int b = 0; b < 32; b++) begin
      wr(16'h5802, 8'(b));
      probe(16'hC000, 1'b1, 1'b1);
      check("R4 C000", rom_addr, exp_rom('hC000, 31, b));
      probe(16'hDFFF, 1'b1, 1'b1);
      check("R4 DFFF", rom_addr, exp_rom('hDFFF, 31, b));
      check("R4 bit13 low", rom_addr[13], 0);
      // R5: top window unaffected by bank registers
      probe(16'hE000 + 16'(b * 201), 1'b1, 1'b1);
      check("R5 fixed", rom_addr, exp_rom('hE000 + b * 201, 31, b));
      bus_idle();
    end
    probe(16'hFFFF, 1'b1, 1'b1);
    check("R5 FFFF", rom_addr, (longint'(1) << ROM_AW) - 1);
    bus_idle();

    // R6: RAM banks
    for (int b = 0; b < 8; b++) begin
      wr(16'h1803, 8'(b) | 8'hF0);
      probe(16'h6000, 1'b1, 1'b1);
      check("R6 6000", ram_addr, b * 8192);
      check("R6 sel", ram_sel, 1);
      check("R6 no we on read", ram_we, 0);
      probe(16'h7FFF, 1'b0, 1'b1);
      check("R6 7FFF", ram_addr, b * 8192 + 8191);
      check("R6 we", ram_we, 1);
      bus_idle();
      probe(16'h7000, 1'b0, 1'b0);
      check("R6 we needs m2", ram_we, 0);
      bus_idle();
    end

    // R2: readback of other registers and lower window
    probe(16'h5803, 1'b1, 1'b1);
    check("R2 r3 readback", cpu_dout, 'hF7);
    check("R2 oe upper", cpu_doe, 1);
    probe(16'h5800, 1'b1, 1'b1);
    check("R2 r0 reads 0", cpu_dout, 0);
    probe(16'h1801, 1'b1, 1'b1);
    check("R2 lower no drive", cpu_doe, 0);
    bus_idle();

    // R7: IRQ latch via both windows
    wr(16'h5802, 8'h20);
    probe(16'h0000, 1'b1, 1'b0);
    check("R7 irq set", irq_n, 0);
    wr(16'h1802, 8'h00);
    probe(16'h0000, 1'b1, 1'b0);
    check("R7 irq clear", irq_n, 1);
    wr(16'h1802, 8'h3F);
    probe(16'h0000, 1'b1, 1'b0);
    check("R7 irq set low win", irq_n, 0);
    wr(16'h5802, 8'hDF);
    probe(16'h0000, 1'b1, 1'b0);
    check("R7 other bits no irq", irq_n, 1);

    // R10: read cycles and held-high writes do not modify registers
    wr(16'h5801, 8'h0A);
    bus_idle();
    @(negedge clk); cpu_addr = 16'h5801; cpu_din = 8'h15; cpu_rw = 1'b1; cpu_m2 = 1'b1;
    @(negedge clk); cpu_m2 = 1'b0;
    @(negedge clk);
    @(negedge clk); cpu_addr = 16'h1801; cpu_din = 8'h16; cpu_rw = 1'b0; cpu_m2 = 1'b1;
    repeat (4) @(negedge clk);
    cpu_rw = 1'b1;
    bus_idle();
    probe(16'h8000, 1'b1, 1'b1);
    check("R10 unchanged", rom_addr, exp_rom('h8000, 10, 0));
    probe(16'h5801, 1'b1, 1'b1);
    check("R10 readback", cpu_dout, 'h0A);
    bus_idle();

    // R8: expansion RAM addressing and windows
    for (int i = 0; i < 256; i += 17) begin
      logic [15:0] a;
      a = 16'h5000 + 16'(i) + 16'((i % 8) << 8);
      probe(a, 1'b1, 1'b1);
      check("R8 addr", xram_addr, i);
      check("R8 read upper", xram_sel, 1);
      probe(a & 16'hBFFF, 1'b1, 1'b1);
      check("R8 read lower", xram_sel, 0);
      bus_idle();
      probe(a & 16'hBFFF, 1'b0, 1'b1);
      check("R8 write lower sel", xram_sel, 1);
      check("R8 write lower we", xram_we, 1);
      bus_idle();
    end

    // R11: page sweep, reads then writes (M2 low on writes)
    for (int p = 0; p < 256; p++) begin
      probe(16'(p << 8) | 16'h0042, 1'b1, 1'b1);
      check("R11 rom read", rom_sel, p >= 'h80);
      check("R11 ram read", ram_sel, (p >= 'h60 && p < 'h80));
      check("R11 xram read", xram_sel, (p >= 'h50 && p < 'h58));
      check("R11 doe read", cpu_doe, (p >= 'h58 && p < 'h60));
    end
    bus_idle();
    for (int p = 0; p < 256; p++) begin
      probe(16'(p << 8) | 16'h0042, 1'b0, 1'b0);
      check("R11 rom write", rom_sel, 0);
      check("R11 xram write", xram_sel, ((p & 'hB8) == 'h10));
    end
    bus_idle();

    finished = 1'b1;
    summary();
  end

endmodule